// File: doc/BRIEF.md
# Receive Bit Clock Recovery DPLL

This block regenerates a receive bit clock from a sliced, demodulated serial data stream at either of two bit rates. A prescaler divides the master clock down to 64 ticks per bit. A 64-state phase counter advances on each tick. The recovered clock `rclk` is low for the first half of the counter's cycle and high for the second half. The data input is sampled when the counter crosses mid-bit, and the sample is presented on `rdata` when the counter wraps. As a result, `rdata` changes on falling edges of `rclk`, and downstream logic latches it on rising edges.

Each transition seen on the input is taken as a measurement of phase error against the ideal transition point, which is counter value 0. A quarter of that error is scheduled as a correction. The correction is applied one count per tick: the counter either advances by two or holds for a tick. This lets the loop pull in within a short alternating 1/0 preamble, and the counter never skips the mid-bit or wrap points.

The block has no flow control: the input is a level-sampled line and the outputs are a free-running clock and data pair, so there is no back-pressure. Demodulation and sync-word search belong to neighbouring blocks.

Top module: `dpll_rx_clkrec`

## Requirements
- R1: While `rst_n` is low, `rclk` and `rdata` are both 1 and the phase counter is cleared, so `rclk` is low on the first clock after `rst_n` rises.
- R2: With no input transitions, the `rclk` period is 64×48 master clocks when `rate_hi` is 0 (1200 bps) and 64×24 master clocks when `rate_hi` is 1 (2400 bps).
- R3: `rclk` is low for counter values 0 to 31 and high for 32 to 63, so with no corrections each level lasts 32 ticks.
- R4: `rdata` changes only in the clock cycle in which `rclk` falls.
- R5: At each rising edge of `rclk`, `rdata` holds the input level sampled at mid-bit of the previous bit period.
- R6: On an alternating 1/0 preamble starting from any phase, the `rclk` falling edge lies within 16 counts (90°) of the input transitions from the 11th preamble bit on.
- R7: On the same preamble, the falling edge lies within 4 counts (22.5°) from the 18th preamble bit on.
- R8: Each input transition schedules a correction of floor(e/4) counts. Here e is the distance from the counter value to 0, taken in the range −32 to 31, and a positive e means the counter lags. The correction is applied one count per tick, so the pending correction stays within ±8 and each `rclk` level lasts between 16 and 48 ticks.
- R9: With a steady input level, `rdata` settles to that level within two bit periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock (3.6864 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_hi | input | 1 | Bit rate select: 0 = 1200 bps, 1 = 2400 bps |
| din | input | 1 | Sliced receive data, asynchronous to the bit clock |
| rclk | output | 1 | Recovered bit clock; falls at bit start, rises at mid-bit |
| rdata | output | 1 | Retimed data, changes on `rclk` falling edges |

## Verification
A stuck or miscounting prescaler or phase counter shows at the ports within one bit period, as a wrong `rclk` period or a wrong level length. A wrong correction sign or gain shows as a falling edge that does not converge toward the input transitions within the 11-bit and 18-bit windows of the preamble. A mis-timed sample or shift register shows up immediately as `rdata` changing away from a falling edge, or as the wrong bit at the next rising edge after the preamble.

// File: rtl/dpll_rx_pkg.sv
package dpll_rx_pkg;
  // master clocks per phase tick for a given bit rate and oversampling ratio
  function automatic int unsigned ticks_div(input int unsigned mclk_hz,
                                            input int unsigned baud,
                                            input int unsigned osr);
    return mclk_hz / (baud * osr);
  endfunction

  typedef enum logic { RATE_LO = 1'b0, RATE_HI = 1'b1 } rate_e;
endpackage

// File: rtl/dpll_rate_div.sv
module dpll_rate_div #(
  parameter int unsigned DIV_LO = 48,
  parameter int unsigned DIV_HI = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_hi,
  output logic tick
);
  localparam int unsigned DMAX = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
  localparam int unsigned CW   = (DMAX > 2) ? $clog2(DMAX) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb begin
    lim  = dpll_rx_pkg::rate_e'(rate_hi) == dpll_rx_pkg::RATE_HI ?
           CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
    tick = (cnt_q >= lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/dpll_din_sync.sv
module dpll_din_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic din_s,
  output logic edge_p
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q[0] <= 1'b1;
    else        sh_q[0] <= din;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) sh_q[g] <= 1'b1;
      else        sh_q[g] <= sh_q[g-1];
    end
  end

  assign din_s  = sh_q[STAGES-1];
  assign edge_p = sh_q[STAGES-1] ^ sh_q[STAGES];
endmodule

// File: rtl/dpll_phase_slew.sv
module dpll_phase_slew #(
  parameter int unsigned PB = 6,
  parameter int unsigned CS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     edge_p,
  output logic [PB-1:0]            phase_q,
  output logic [PB-1:0]            phase_nx,
  output logic signed [PB-CS:0]    pend_q,
  output logic                     mid_cross,
  output logic                     wrap
);
  localparam int unsigned PW = PB - CS + 1;

  logic signed [PB:0]   err;
  logic signed [PB:0]   corr;
  logic [1:0]           step;
  logic signed [PW-1:0] pend_nx;

  always_comb begin
    // distance from the current count to the ideal transition point (0)
    err  = -$signed({phase_q[PB-1], phase_q});
    corr = err >>> CS;
    if (!tick)            step = 2'd0;
    else if (pend_q > 0)  step = 2'd2;
    else if (pend_q < 0)  step = 2'd0;
    else                  step = 2'd1;
    phase_nx = phase_q + PB'(step);
    if (edge_p)                  pend_nx = $signed(corr[PW-1:0]);
    else if (tick && pend_q > 0) pend_nx = pend_q - PW'(1);
    else if (tick && pend_q < 0) pend_nx = pend_q + PW'(1);
    else                         pend_nx = pend_q;
    mid_cross = !phase_q[PB-1] &&  phase_nx[PB-1];
    wrap      =  phase_q[PB-1] && !phase_nx[PB-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      pend_q  <= '0;
    end else begin
      phase_q <= phase_nx;
      pend_q  <= pend_nx;
    end
  end
endmodule

// File: rtl/dpll_retimer.sv
module dpll_retimer (
  input  logic clk,
  input  logic rst_n,
  input  logic nx_msb,
  input  logic mid_cross,
  input  logic wrap,
  input  logic din_s,
  output logic rclk,
  output logic rdata
);
  logic samp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      rclk   <= 1'b1;
      rdata  <= 1'b1;
    end else begin
      rclk <= nx_msb;
      if (mid_cross) samp_q <= din_s;
      if (wrap)      rdata  <= samp_q;
    end
  end
endmodule

// File: rtl/dpll_rx_clkrec.sv
module dpll_rx_clkrec #(
  parameter int unsigned MCLK_HZ     = 3686400,
  parameter int unsigned BAUD_LO     = 1200,
  parameter int unsigned BAUD_HI     = 2400,
  parameter int unsigned PHASE_BITS  = 6,
  parameter int unsigned CORR_SHIFT  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_hi,
  input  logic din,
  output logic rclk,
  output logic rdata
);
  localparam int unsigned OSR    = 1 << PHASE_BITS;
  localparam int unsigned DIV_LO = dpll_rx_pkg::ticks_div(MCLK_HZ, BAUD_LO, OSR);
  localparam int unsigned DIV_HI = dpll_rx_pkg::ticks_div(MCLK_HZ, BAUD_HI, OSR);
  localparam int unsigned PW     = PHASE_BITS - CORR_SHIFT + 1;

  logic                  tick;
  logic                  din_s;
  logic                  edge_p;
  logic [PHASE_BITS-1:0] phase_q;
  logic [PHASE_BITS-1:0] phase_nx;
  logic signed [PW-1:0]  pend_q;
  logic                  mid_cross;
  logic                  wrap;

  dpll_rate_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
    .clk(clk), .rst_n(rst_n), .rate_hi(rate_hi), .tick(tick)
  );

  dpll_din_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(din), .din_s(din_s), .edge_p(edge_p)
  );

  dpll_phase_slew #(.PB(PHASE_BITS), .CS(CORR_SHIFT)) u_slew (
    .clk(clk), .rst_n(rst_n), .tick(tick), .edge_p(edge_p),
    .phase_q(phase_q), .phase_nx(phase_nx), .pend_q(pend_q),
    .mid_cross(mid_cross), .wrap(wrap)
  );

  dpll_retimer u_rt (
    .clk(clk), .rst_n(rst_n), .nx_msb(phase_nx[PHASE_BITS-1]),
    .mid_cross(mid_cross), .wrap(wrap), .din_s(din_s),
    .rclk(rclk), .rdata(rdata)
  );
endmodule

// File: rtl/dpll_rx_clkrec_chk.sv
module dpll_rx_clkrec_chk #(
  parameter int unsigned PB = 6,
  parameter int unsigned CS = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic [PB-1:0]         phase,
  input logic signed [PB-CS:0] pend,
  input logic                  rclk,
  input logic                  rdata
);
  localparam int PEND_LIM = (1 << (PB - 1)) >> CS;

  // R1: reset forces both outputs high
  assert_reset_hold_R1: assert property (@(posedge clk)
    !rst_n |=> (rclk && rdata));

  // R2: the phase counter only moves on a prescaler tick
  assert_tick_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));

  // R3: rclk levels change only after a tick
  assert_rclk_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && (rclk != $past(rclk))) |-> $past(tick));

  // R4: retimed data moves only with a falling rclk
  assert_data_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != $past(rdata)) |-> (!rclk && $past(rclk)));

  // R8: pending correction stays within a quarter of half a bit
  assert_pend_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($signed(pend) <= PEND_LIM) && ($signed(pend) >= -PEND_LIM)));
endmodule

bind dpll_rx_clkrec dpll_rx_clkrec_chk #(.PB(PHASE_BITS), .CS(CORR_SHIFT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase_q), .pend(pend_q),
  .rclk(rclk), .rdata(rdata)
);

// File: tb/dpll_rx_clkrec_test.sv
`timescale 1ns/1ps
module dpll_rx_clkrec_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_hi = 1'b0;
  logic din = 1'b1;
  logic rclk;
  logic rdata;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int r4_changes = 0;
  int r4_bad = 0;

  always #2.5 clk = ~clk;

  dpll_rx_clkrec uut (
    .clk(clk), .rst_n(rst_n), .rate_hi(rate_hi), .din(din),
    .rclk(rclk), .rdata(rdata)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4 monitor: every change of rdata must coincide with an rclk fall
  logic m_rclk = 1'b1, m_rdata = 1'b1, m_rst = 1'b0;
  always @(negedge clk) begin
    if (rst_n && m_rst && (rdata !== m_rdata)) begin
      r4_changes++;
      if (!(m_rclk === 1'b1 && rclk === 1'b0)) r4_bad++;
    end
    m_rclk = rclk; m_rdata = rdata; m_rst = rst_n;
  end

  task automatic do_reset(input bit rate, input logic lvl);
    @(negedge clk);
    rst_n = 1'b0; rate_hi = rate; din = lvl;
    repeat (4) @(negedge clk);
    chk(rclk === 1'b1, "R1 rclk in reset", int'(rclk), 1);
    chk(rdata === 1'b1, "R1 rdata in reset", int'(rdata), 1);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b1);
    @(negedge clk);
    chk(rclk === 1'b0, "R1 counter cleared, rclk low after release", int'(rclk), 0);
  endtask

  task automatic t_free(input bit rate, input logic lvl);
    int pre = rate ? 24 : 48;
    int f[3];
    int r0 = -1;
    int nf = 0;
    logic pr = 1'b1;
    do_reset(rate, lvl);
    for (int i = 0; i < 3 * 64 * pre && nf < 3; i++) begin
      @(negedge clk);
      if (pr === 1'b1 && rclk === 1'b0) begin f[nf] = cyc; nf++; end
      if (pr === 1'b0 && rclk === 1'b1 && r0 < 0) r0 = cyc;
      pr = rclk;
    end
    chk(nf == 3, "R2 three falls seen", nf, 3);
    if (nf == 3) begin
      chk(f[2] - f[1] == 64 * pre, "R2 bit period", f[2] - f[1], 64 * pre);
      chk((r0 - f[0] >= 32 * pre - 2) && (r0 - f[0] <= 32 * pre + 2),
          "R3 low level length", r0 - f[0], 32 * pre);
      chk((f[1] - r0 >= 32 * pre - 2) && (f[1] - r0 <= 32 * pre + 2),
          "R3 high level length", f[1] - r0, 32 * pre);
    end
    chk(rdata === lvl, "R9 rdata follows steady input", int'(rdata), int'(lvl));
  endtask

  task automatic t_lock(input bit rate, input int offset, input int npre,
                        input int ndata, input logic [15:0] word);
    int pre = rate ? 24 : 48;
    int bitc = 64 * pre;
    int t0;
    bit done = 1'b0;
    logic tx [64];
    do_reset(rate, 1'b1);
    repeat (offset) @(negedge clk);
    t0 = cyc;
    fork
      begin
        for (int i = 0; i < npre + ndata; i++) begin
          logic b;
          b = (i < npre) ? logic'(i % 2) : word[15 - (i - npre)];
          tx[i] = b;
          din = b;
          repeat (bitc) @(negedge clk);
        end
        done = 1'b1;
      end
      begin
        int last = -1;
        logic pr = rclk;
        while (!done) begin
          @(negedge clk);
          if (pr !== rclk) begin
            int now = cyc;
            int kr = (now - t0 + bitc / 2) / bitc;
            int kd = (now - t0) / bitc;
            int d = (now - t0) % bitc;
            if (d > bitc / 2) d = d - bitc;
            if (d < 0) d = -d;
            if (last >= 0)
              chk((now - last >= 16 * pre - 2) && (now - last <= 48 * pre + 2),
                  "R8 level length bound", now - last, 32 * pre);
            last = now;
            if (rclk === 1'b0 && kr >= 11 && kr < npre)
              chk(d <= 16 * pre + 8, "R6 90 deg window", d, 16 * pre);
            if (rclk === 1'b0 && kr >= 18 && kr < npre)
              chk(d <= 4 * pre + 8, "R7 22.5 deg window", d, 4 * pre);
            if (rclk === 1'b1 && kd >= npre + 1 && kd < npre + ndata)
              chk(rdata === tx[kd - 1], "R5 retimed bit", int'(rdata), int'(tx[kd - 1]));
          end
          pr = rclk;
        end
      end
    join
  endtask

  initial begin
    t_reset();
    t_free(1'b0, 1'b1);
    t_free(1'b1, 1'b0);
    t_lock(1'b1, 700, 20, 16, 16'hB5C3);
    t_lock(1'b0, 32 * 48 + 5, 19, 0, 16'h0000);
    chk(r4_changes > 0, "R4 rdata changed at least once", r4_changes, 1);
    chk(r4_bad == 0, "R4 rdata changes only on rclk fall", r4_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 195000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule